// File: doc/BRIEF.md
# Nested Trap Entry Controller

This block performs the state changes a 64-bit register-window processor makes when it takes a trap, for a machine with several nested trap levels. In one cycle it raises the trap level and stores the interrupted context in a trap-stack slot chosen by the new level. It replaces the processor-state word so that exactly one of three global register sets is active. It moves the current window pointer when the trap is a window trap. It forms the vector address that becomes the new program counter.

The pipeline presents a single-cycle `trap_req` along with the trap type and a snapshot of the architectural state. The block answers one cycle later. On success it pulses `done` and presents the new state on its outputs. If the machine is already at the deepest trap level, it pulses `err` instead and holds every output and every stack slot. A read port on the trap stack lets the surrounding logic, or a test, look at any saved slot.

Top module: `trap_entry_ctrl`

## Requirements
- R1: When `trap_req` is high and `cur_tl` is below MAXTL (default 5), `done` is high in the next cycle and `tl_o` equals `cur_tl`+1.
- R2: When the accepted trap starts at level MAXTL-1, bit 5 (RED) of `pstate_o` is set. The saved processor state also has bit 5 set before masking. At any lower level, RED is clear in `pstate_o`.
- R3: When `trap_req` is high and `cur_tl` >= MAXTL, `err` is high in the next cycle and `done` stays low. All outputs keep their previous values, and no trap-stack slot changes.
- R4: The saved state word is 40 bits. It holds CCR in bits 39:32, ASI in bits 31:24, (processor state AND 0xF3F) in bits 19:8 and the window pointer in bits 7:0. Bits 23:20 are zero.
- R5: On acceptance, the slot indexed by the new trap level receives the saved state word, PC, NPC and trap type. These appear on the `rd_*` outputs when `rd_idx` selects that slot.
- R6: `pstate_o` equals bit 4 (PEF) | bit 2 (PRIV) | one global-set bit, plus RED per R2. Trap type 0x060 selects bit 11 (interrupt set). Types 0x008, 0x030 and 0x064..0x06F select bit 10 (MMU set). All other types select bit 0 (alternate set).
- R7: Trap type 0x024 (clean window) gives `cwp_o` = (`cur_cwp` - 1) mod NWIN.
- R8: A type with (type AND 0x1C0) = 0x080 (spill) gives `cwp_o` = (`cur_cwp` - `cur_cansave` - 2) mod NWIN. A type with (type AND 0x1C0) = 0x0C0 (fill) gives `cwp_o` = (`cur_cwp` + 1) mod NWIN. Any other trap type, except 0x024, leaves `cwp_o` = `cur_cwp`.
- R9: The vector equals `trap_base` with bits 14:0 cleared, ORed with (type << 5), with bit 14 set when the new trap level is greater than 1.
- R10: After acceptance, `pc_o` equals the vector and `npc_o` equals the vector + 4.
- R11: After reset, `done`, `err`, `tl_o`, `pstate_o`, `cwp_o`, `pc_o`, `npc_o` and every trap-stack slot are zero. `done` is high for one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Trap type code |
| cur_pc | input | 64 | Program counter at the trap |
| cur_npc | input | 64 | Next program counter at the trap |
| cur_tl | input | TLW | Current trap level |
| cur_pstate | input | 12 | Current processor-state word |
| cur_asi | input | 8 | Current address-space identifier |
| cur_ccr | input | 8 | Current condition codes |
| cur_cwp | input | CWPW | Current window pointer |
| cur_cansave | input | CWPW | Count of windows that can be saved |
| trap_base | input | 64 | Trap base address |
| rd_idx | input | TLW | Trap-stack slot to read |
| done | output | 1 | Trap accepted (one-cycle pulse) |
| err | output | 1 | Trap refused at the deepest level (pulse) |
| tl_o | output | TLW | New trap level |
| pstate_o | output | 12 | New processor-state word |
| cwp_o | output | CWPW | New window pointer |
| pc_o | output | 64 | New program counter (vector) |
| npc_o | output | 64 | New next program counter |
| rd_tstate | output | 40 | Saved state word of slot `rd_idx` |
| rd_pc | output | 64 | Saved PC of slot `rd_idx` |
| rd_npc | output | 64 | Saved NPC of slot `rd_idx` |
| rd_tt | output | 9 | Saved trap type of slot `rd_idx` |

## Verification
Two functions can act in the same cycle: forcing RED on entry to the top level, and moving the window pointer for a spill trap. A further coincidence is that the nested-vector offset is always present at that level. The bench provokes this case with a spill trap at level MAXTL-1 and with the processor-state management bits set. It then judges `pstate_o`, `cwp_o`, the vector and the saved slot together against the scoreboard model. A request at the deepest level follows at once, to show that the refusal path holds the top slot and the outputs.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    // processor-state bit positions
    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam int PS_MG   = 10;
    localparam int PS_IG   = 11;
    localparam logic [11:0] PS_SAVE_MASK = 12'hF3F;

    // trap type codes the controller decodes
    localparam logic [8:0] TT_INTVEC    = 9'h060;
    localparam logic [8:0] TT_IACCESS   = 9'h008;
    localparam logic [8:0] TT_DACCESS   = 9'h030;
    localparam logic [8:0] TT_MMU_LO    = 9'h064;
    localparam logic [8:0] TT_MMU_HI    = 9'h06F;
    localparam logic [8:0] TT_CLEANWIN  = 9'h024;
    localparam logic [8:0] TT_CLASS_MSK = 9'h1C0;
    localparam logic [8:0] TT_SPILL     = 9'h080;
    localparam logic [8:0] TT_FILL      = 9'h0C0;

    localparam int TSTATE_W = 40;

    typedef enum logic [1:0] {GSET_ALT, GSET_MMU, GSET_INT} gset_e;
    typedef enum logic [1:0] {WIN_KEEP, WIN_CLEAN, WIN_SPILL, WIN_FILL} winop_e;

    typedef struct packed {
        logic [8:0]          tt;
        logic [63:0]         npc;
        logic [63:0]         pc;
        logic [TSTATE_W-1:0] tstate;
    } tframe_t;

    function automatic gset_e pick_gset(input logic [8:0] tt);
        if (tt == TT_INTVEC)
            return GSET_INT;
        if (tt == TT_IACCESS || tt == TT_DACCESS || (tt >= TT_MMU_LO && tt <= TT_MMU_HI))
            return GSET_MMU;
        return GSET_ALT;
    endfunction

    function automatic winop_e pick_winop(input logic [8:0] tt);
        if (tt == TT_CLEANWIN)                  return WIN_CLEAN;
        if ((tt & TT_CLASS_MSK) == TT_SPILL)    return WIN_SPILL;
        if ((tt & TT_CLASS_MSK) == TT_FILL)     return WIN_FILL;
        return WIN_KEEP;
    endfunction

    function automatic logic [11:0] build_pstate(input gset_e g, input logic red);
        logic [11:0] p;
        p = '0;
        p[PS_PEF]  = 1'b1;
        p[PS_PRIV] = 1'b1;
        p[PS_RED]  = red;
        case (g)
            GSET_INT: p[PS_IG] = 1'b1;
            GSET_MMU: p[PS_MG] = 1'b1;
            default:  p[PS_AG] = 1'b1;
        endcase
        return p;
    endfunction

    function automatic logic [TSTATE_W-1:0] pack_tstate(input logic [7:0] ccr,
                                                        input logic [7:0] asi,
                                                        input logic [11:0] ps,
                                                        input logic [7:0] cwp8);
        return {ccr, asi, 4'b0000, ps & PS_SAVE_MASK, cwp8};
    endfunction

endpackage

// File: rtl/trap_level_calc.sv
module trap_level_calc #(
    parameter int MAXTL = 5,
    parameter int TLW   = 3
) (
    input  logic [TLW-1:0] cur_tl,
    output logic [TLW-1:0] nxt_tl,
    output logic           reject,
    output logic           red,
    output logic           nested
);
    always_comb begin
        reject = (cur_tl >= TLW'(MAXTL));
        nxt_tl = cur_tl + TLW'(1);
        red    = (cur_tl == TLW'(MAXTL - 1));
        nested = (cur_tl != '0);
    end
endmodule

// File: rtl/trap_window_adj.sv
module trap_window_adj
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CWPW = 3
) (
    input  winop_e          op,
    input  logic [CWPW-1:0] cwp,
    input  logic [CWPW-1:0] cansave,
    output logic [CWPW-1:0] nxt_cwp
);
    localparam int SW = CWPW + 3;
    localparam bit POW2 = ((1 << CWPW) == NWIN);

    logic [SW-1:0] up_sum;
    logic [SW-1:0] dn_amt;
    logic [SW-1:0] dn_sum;
    logic [SW-1:0] sel_sum;

    always_comb begin
        up_sum = SW'(cwp) + SW'(1);
        dn_amt = (op == WIN_SPILL) ? (SW'(cansave) + SW'(2)) : SW'(1);
        dn_sum = SW'(cwp) + SW'(2 * NWIN) - dn_amt;
        case (op)
            WIN_FILL:             sel_sum = up_sum;
            WIN_CLEAN, WIN_SPILL: sel_sum = dn_sum;
            default:              sel_sum = SW'(cwp);
        endcase
    end

    generate
        if (POW2) begin : g_wrap_pow2
            assign nxt_cwp = sel_sum[CWPW-1:0];
        end else begin : g_wrap_mod
            logic [SW-1:0] rem;
            assign rem     = sel_sum % SW'(NWIN);
            assign nxt_cwp = rem[CWPW-1:0];
        end
    endgenerate
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen (
    input  logic [63:0] base,
    input  logic [8:0]  tt,
    input  logic        nested,
    output logic [63:0] vec,
    output logic [63:0] vec_next
);
    always_comb begin
        vec      = {base[63:15], nested, tt, 5'b00000};
        vec_next = vec + 64'd4;
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
    import trap_entry_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  tframe_t       wr_data,
    input  logic [IW-1:0] rd_idx,
    output tframe_t       rd_data
);
    tframe_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (wr_en && int'(wr_idx) < DEPTH) begin
            slots[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (int'(rd_idx) == i) rd_data = slots[i];
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int MAXTL = 5,
    parameter int NWIN  = 8,
    localparam int TLW  = $clog2(MAXTL + 1),
    localparam int CWPW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_req,
    input  logic [8:0]      trap_type,
    input  logic [63:0]     cur_pc,
    input  logic [63:0]     cur_npc,
    input  logic [TLW-1:0]  cur_tl,
    input  logic [11:0]     cur_pstate,
    input  logic [7:0]      cur_asi,
    input  logic [7:0]      cur_ccr,
    input  logic [CWPW-1:0] cur_cwp,
    input  logic [CWPW-1:0] cur_cansave,
    input  logic [63:0]     trap_base,
    input  logic [TLW-1:0]  rd_idx,
    output logic            done,
    output logic            err,
    output logic [TLW-1:0]  tl_o,
    output logic [11:0]     pstate_o,
    output logic [CWPW-1:0] cwp_o,
    output logic [63:0]     pc_o,
    output logic [63:0]     npc_o,
    output logic [39:0]     rd_tstate,
    output logic [63:0]     rd_pc,
    output logic [63:0]     rd_npc,
    output logic [8:0]      rd_tt
);
    localparam int DEPTH = MAXTL + 1;

    logic [TLW-1:0]  nxt_tl;
    logic            reject, red, nested, accept;
    logic [CWPW-1:0] nxt_cwp;
    logic [63:0]     vec, vec_next;
    logic [11:0]     ps_for_save;
    tframe_t         frame, rd_frame;
    gset_e           gsel;
    winop_e          wop;

    assign gsel   = pick_gset(trap_type);
    assign wop    = pick_winop(trap_type);
    assign accept = trap_req && !reject;

    trap_level_calc #(.MAXTL(MAXTL), .TLW(TLW)) u_level (
        .cur_tl (cur_tl),
        .nxt_tl (nxt_tl),
        .reject (reject),
        .red    (red),
        .nested (nested)
    );

    trap_window_adj #(.NWIN(NWIN), .CWPW(CWPW)) u_win (
        .op      (wop),
        .cwp     (cur_cwp),
        .cansave (cur_cansave),
        .nxt_cwp (nxt_cwp)
    );

    trap_vector_gen u_vec (
        .base     (trap_base),
        .tt       (trap_type),
        .nested   (nested),
        .vec      (vec),
        .vec_next (vec_next)
    );

    always_comb begin
        ps_for_save         = cur_pstate;
        ps_for_save[PS_RED] = cur_pstate[PS_RED] | red;
        frame.tstate = pack_tstate(cur_ccr, cur_asi, ps_for_save, 8'(cur_cwp));
        frame.pc     = cur_pc;
        frame.npc    = cur_npc;
        frame.tt     = trap_type;
    end

    trap_stack #(.DEPTH(DEPTH), .IW(TLW)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_idx  (nxt_tl),
        .wr_data (frame),
        .rd_idx  (rd_idx),
        .rd_data (rd_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            err      <= 1'b0;
            tl_o     <= '0;
            pstate_o <= '0;
            cwp_o    <= '0;
            pc_o     <= '0;
            npc_o    <= '0;
        end else begin
            done <= accept;
            err  <= trap_req && reject;
            if (accept) begin
                tl_o     <= nxt_tl;
                pstate_o <= build_pstate(gsel, red);
                cwp_o    <= nxt_cwp;
                pc_o     <= vec;
                npc_o    <= vec_next;
            end
        end
    end

    assign rd_tstate = rd_frame.tstate;
    assign rd_pc     = rd_frame.pc;
    assign rd_npc    = rd_frame.npc;
    assign rd_tt     = rd_frame.tt;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int MAXTL = 5,
    parameter int TLW   = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           trap_req,
    input logic [TLW-1:0] cur_tl,
    input logic [63:0]    trap_base,
    input logic           done,
    input logic           err,
    input logic [TLW-1:0] tl_o,
    input logic [11:0]    pstate_o,
    input logic [63:0]    pc_o
);
    // R1
    tl_step_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (tl_o == $past(cur_tl) + TLW'(1)));

    // R2
    red_top_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pstate_o[5] == ($past(cur_tl) == TLW'(MAXTL - 1))));

    // R3
    reject_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_req && cur_tl >= TLW'(MAXTL)) |=> (err && !done));

    // R3
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($stable(tl_o) && $stable(pc_o) && $stable(pstate_o)));

    // R6
    gset_one_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($countones({pstate_o[11], pstate_o[10], pstate_o[0]}) == 1
                  && pstate_o[2] && pstate_o[4]));

    // R9
    vec_base_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pc_o[63:15] == $past(trap_base[63:15])));

    // R11
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.MAXTL(MAXTL), .TLW(TLW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trap_req  (trap_req),
    .cur_tl    (cur_tl),
    .trap_base (trap_base),
    .done      (done),
    .err       (err),
    .tl_o      (tl_o),
    .pstate_o  (pstate_o),
    .pc_o      (pc_o)
);

// File: tb/trap_entry_ctrl_tb.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb;
    localparam int MAXTL = 5;
    localparam int NWIN  = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        trap_req;
    logic [8:0]  trap_type;
    logic [63:0] cur_pc, cur_npc, trap_base;
    logic [2:0]  cur_tl, rd_idx;
    logic [11:0] cur_pstate;
    logic [7:0]  cur_asi, cur_ccr;
    logic [2:0]  cur_cwp, cur_cansave;
    logic        done, err;
    logic [2:0]  tl_o, cwp_o;
    logic [11:0] pstate_o;
    logic [63:0] pc_o, npc_o, rd_pc, rd_npc;
    logic [39:0] rd_tstate;
    logic [8:0]  rd_tt;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    trap_entry_ctrl #(.MAXTL(MAXTL), .NWIN(NWIN)) u_dut (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_type(trap_type),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_tl(cur_tl), .cur_pstate(cur_pstate),
        .cur_asi(cur_asi), .cur_ccr(cur_ccr), .cur_cwp(cur_cwp), .cur_cansave(cur_cansave),
        .trap_base(trap_base), .rd_idx(rd_idx), .done(done), .err(err), .tl_o(tl_o),
        .pstate_o(pstate_o), .cwp_o(cwp_o), .pc_o(pc_o), .npc_o(npc_o),
        .rd_tstate(rd_tstate), .rd_pc(rd_pc), .rd_npc(rd_npc), .rd_tt(rd_tt)
    );

    typedef struct {
        bit          is_err;
        logic [2:0]  tl;
        logic [11:0] ps;
        logic [2:0]  cwp;
        logic [63:0] pc;
        logic [63:0] npc;
        logic [2:0]  idx;
        logic [39:0] ts;
        logic [63:0] spc;
        logic [63:0] snpc;
        logic [8:0]  stt;
        string       tag;
    } exp_t;

    exp_t q[$];

    // model state
    logic [2:0]  m_tl = '0, m_cwp = '0;
    logic [11:0] m_ps = '0;
    logic [63:0] m_pc = '0, m_npc = '0;
    logic [39:0] s_ts  [MAXTL+1];
    logic [63:0] s_pc  [MAXTL+1];
    logic [63:0] s_npc [MAXTL+1];
    logic [8:0]  s_tt  [MAXTL+1];

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic do_trap(input string tag, input logic [8:0] tt, input logic [2:0] tl,
                           input logic [11:0] ps, input logic [2:0] cwp, input logic [2:0] cans,
                           input logic [63:0] tba, input logic [63:0] pc, input bit keep_req);
        exp_t e;
        int   ntl, c;
        logic [11:0] psv, g;
        e.tag = tag;
        if (int'(tl) >= MAXTL) begin
            e.is_err = 1;
        end else begin
            e.is_err = 0;
            ntl = int'(tl) + 1;
            psv = ps;
            if (ntl == MAXTL) psv = psv | 12'h020;
            psv = psv & 12'hF3F;
            if (tt == 9'h060) g = 12'h800;
            else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) g = 12'h400;
            else g = 12'h001;
            m_ps = 12'h014 | g | ((ntl == MAXTL) ? 12'h020 : 12'h000);
            c = int'(cwp);
            if (tt == 9'h024) c = (c + NWIN - 1) % NWIN;
            else if ((tt & 9'h1C0) == 9'h080) c = (c - int'(cans) - 2 + 2 * NWIN) % NWIN;
            else if ((tt & 9'h1C0) == 9'h0C0) c = (c + 1) % NWIN;
            m_cwp = 3'(c);
            m_tl  = 3'(ntl);
            m_pc  = (tba & ~64'h7FFF) | ((ntl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
            m_npc = m_pc + 64'd4;
            s_ts[ntl]  = {8'hC3, 8'h5A, 4'h0, psv, 5'b0, cwp};
            s_pc[ntl]  = pc;
            s_npc[ntl] = pc + 64'd4;
            s_tt[ntl]  = tt;
        end
        e.tl = m_tl; e.ps = m_ps; e.cwp = m_cwp; e.pc = m_pc; e.npc = m_npc;
        e.idx  = e.is_err ? 3'(MAXTL) : m_tl;
        e.ts   = s_ts[e.idx]; e.spc = s_pc[e.idx]; e.snpc = s_npc[e.idx]; e.stt = s_tt[e.idx];
        q.push_back(e);
        trap_type = tt; cur_tl = tl; cur_pstate = ps; cur_cwp = cwp; cur_cansave = cans;
        trap_base = tba; cur_pc = pc; cur_npc = pc + 64'd4; cur_asi = 8'h5A; cur_ccr = 8'hC3;
        trap_req = 1'b1;
        @(negedge clk);
        if (!keep_req) trap_req = 1'b0;
    endtask

    // monitor: pop expected item when the design answers
    always @(negedge clk) begin
        if (!rst && (done || err)) begin
            exp_t e;
            if (q.size() == 0) begin
                chk("R11", "unexpected response", 64'(done), 64'd0);
            end else begin
                e = q.pop_front();
                if (e.is_err) begin
                    chk("R3", {e.tag, " err"}, 64'(err), 64'd1);
                    chk("R3", {e.tag, " done low"}, 64'(done), 64'd0);
                end else begin
                    chk("R1", {e.tag, " done"}, 64'(done), 64'd1);
                end
                chk("R1", {e.tag, " tl"}, 64'(tl_o), 64'(e.tl));
                chk("R6", {e.tag, " pstate (R2 red)"}, 64'(pstate_o), 64'(e.ps));
                chk("R8", {e.tag, " cwp (R7)"}, 64'(cwp_o), 64'(e.cwp));
                chk("R9", {e.tag, " vector"}, pc_o, e.pc);
                chk("R10", {e.tag, " npc"}, npc_o, e.npc);
                rd_idx = e.idx;
                #1;
                chk("R4", {e.tag, " saved state"}, 64'(rd_tstate), 64'(e.ts));
                chk("R5", {e.tag, " saved pc"}, rd_pc, e.spc);
                chk("R5", {e.tag, " saved npc"}, rd_npc, e.snpc);
                chk("R5", {e.tag, " saved type"}, 64'(rd_tt), 64'(e.stt));
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R11 watchdog expired: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i <= MAXTL; i++) begin
            s_ts[i] = '0; s_pc[i] = '0; s_npc[i] = '0; s_tt[i] = '0;
        end
        rst = 1'b1; trap_req = 1'b0; trap_type = '0; cur_pc = '0; cur_npc = '0;
        cur_tl = '0; cur_pstate = '0; cur_asi = '0; cur_ccr = '0; cur_cwp = '0;
        cur_cansave = '0; trap_base = '0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "reset done", 64'(done), 64'd0);
        chk("R11", "reset err", 64'(err), 64'd0);
        chk("R11", "reset tl", 64'(tl_o), 64'd0);
        chk("R11", "reset pc", pc_o, 64'd0);
        rd_idx = 3'd1; #1;
        chk("R11", "reset slot", rd_pc, 64'd0);

        do_trap("intvec",   9'h060, 3'd0, 12'h016, 3'd2, 3'd1, 64'hFFFF_0000_1234_5678, 64'h1000, 0);
        do_trap("dfault",   9'h030, 3'd1, 12'h0C1, 3'd3, 3'd0, 64'h0000_0000_0040_0000, 64'h2000, 0);
        do_trap("dmiss",    9'h066, 3'd2, 12'h404, 3'd4, 3'd0, 64'h0000_0000_0040_0000, 64'h3000, 0);
        do_trap("cleanwin", 9'h024, 3'd0, 12'h001, 3'd0, 3'd0, 64'h0000_0000_0080_7FFF, 64'h4000, 0);
        do_trap("spill",    9'h084, 3'd0, 12'h001, 3'd1, 3'd3, 64'h0000_0000_0080_0000, 64'h5000, 0);
        do_trap("fill",     9'h0C5, 3'd1, 12'h001, 3'd7, 3'd2, 64'h0000_0000_0080_0000, 64'h6000, 0);
        do_trap("trapinsn", 9'h100, 3'd3, 12'h800, 3'd5, 3'd5, 64'h0000_0000_00C0_0000, 64'h7000, 0);
        // coincidence: spill at MAXTL-1 with RED forced and MM bits set
        do_trap("top-spill",9'h088, 3'd4, 12'h0C4, 3'd6, 3'd7, 64'h0000_0000_00C0_0000, 64'h8000, 1);
        do_trap("at-max",   9'h060, 3'd5, 12'h016, 3'd1, 3'd1, 64'h0000_0000_0100_0000, 64'h9000, 0);
        do_trap("above-max",9'h0C0, 3'd7, 12'h016, 3'd1, 3'd1, 64'h0000_0000_0100_0000, 64'hA000, 0);
        // back-to-back accepted requests
        do_trap("b2b-a",    9'h008, 3'd0, 12'h001, 3'd4, 3'd0, 64'h0000_0000_0200_0000, 64'hB000, 1);
        do_trap("b2b-b",    9'h06C, 3'd1, 12'h001, 3'd4, 3'd0, 64'h0000_0000_0200_0000, 64'hC000, 0);
        repeat (4) @(negedge clk);
        // R11 done is a single pulse
        chk("R11", "done idle", 64'(done), 64'd0);
        chk("R11", "queue drained", 64'(q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule